// File: doc/BRIEF.md
# Write-Protected Pin Function Register File

This block holds the configuration state of a pin function controller: one select bit per pin choosing GPIO or a peripheral, a 4-bit peripheral function code per pin, a drive-strength code per pin, and per-pin pull enable and pull direction bits. It presents that state continuously to the pad logic and exposes it through a simple register port. The port has a one-cycle write strobe and a combinational read path. It has no back-pressure: every write is taken in the cycle it is presented, and read data follows the address within the same cycle.

Three register groups are guarded: the pin select, the function select and the drive registers. Software must first write the bitwise complement of the intended value to the guard word. The next bus write of any kind uses up that unlock. A guarded write that arrives without a matching unlock is discarded and raises a sticky violation flag. The pull registers are not guarded. Every register can be read back, so software can update single fields by read-modify-write.

Drive codes use a 24 mA full scale. A pin has either a 3-bit field (3 mA per step) or a 2-bit field (6 mA per step), selected per pin by the `DRV3_SEL` parameter. The stored code is (mA / step) - 1.

Top module: `pinfunc_regfile`

## Requirements
- R1: After reset, all pin select bits are 0 (GPIO), all function fields are 0, every drive field is all ones within its width, pull enable and pull direction are 0, and the violation flag (status word 0x004, bit 0) is 0.
- R2: A write to a guarded register (pin select at 0x100 + 4*b, function select at 0x200 + 4*r, drive at 0x300 + 4*r) takes effect only if the previous bus write went to the guard word 0x000 and carried exactly the bitwise complement of the new data. Idle cycles may separate the two writes.
- R3: A guarded write that has no matching unlock leaves the target register unchanged and sets the violation flag. A matching unlock is missing when the previous write was not a guard write or when the key differs from the complement of the data.
- R4: An unlock is spent by the next bus write, whatever its target. A second guarded write, or a guarded write that follows an intervening unguarded write, is dropped.
- R5: A guard write that arrives while an unlock is armed disarms it, so a guarded write that follows two back-to-back guard writes is dropped.
- R6: Pin p is driven by bit p%32 of the pin select register of bank p/32; 1 selects the peripheral and 0 selects GPIO (`pad_periph_sel[p]`).
- R7: The function code of pin p is bits [4*(p%8)+3 : 4*(p%8)] of function register p/8 and appears on `pad_func[4p+3:4p]`.
- R8: The drive code of pin p sits in the 4-bit slot at bit 4*(p%8) of drive register p/8. The code is 3 bits wide when bit p of `DRV3_SEL` is 1 and 2 bits wide otherwise. Unused slot bits read 0 and ignore writes. The code appears zero-extended on `pad_drive[3p+2:3p]`.
- R9: Pull enable (0x400 + 4*b) and pull direction (0x500 + 4*b) take plain writes with no unlock. Pin p pulls up when both its bits are 1 and pulls down when its enable bit is 1 and its direction bit is 0. With enable 0, both pull outputs are 0.
- R10: Reads of the guard word, of unmapped or misaligned offsets, and of out-of-range indices return 0. Writes to those unmapped locations change no register.
- R11: The violation flag stays set until software writes the status word with bit 0 set. `wp_violation` mirrors the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| wp_violation | output | 1 | Sticky flag for a dropped guarded write |
| pad_periph_sel | output | NUM_BANKS*32 | Per pin: 1 selects the peripheral, 0 selects GPIO |
| pad_func | output | NUM_BANKS*128 | Per pin 4-bit function code |
| pad_drive | output | NUM_BANKS*96 | Per pin 3-bit drive code |
| pad_pull_up | output | NUM_BANKS*32 | Per pin pull-up enable |
| pad_pull_dn | output | NUM_BANKS*32 | Per pin pull-down enable |

## Verification
In a single cycle, one write both spends or cancels the armed unlock and decides whether its own target register updates or the violation flag sets. The stimulus puts guard writes, guarded writes with right and wrong keys, unguarded writes and unmapped writes back to back in random order. It also inserts deliberate double-guard and intervening-write cases. After every write, a bench model of the unlock state, the registers and the flag predicts the pad outputs, and periodic reads of every register compare the stored state against that model.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  localparam int REG_W = 32;
  localparam int IDX_W = 6;

  typedef enum logic [3:0] {
    RG_CTRL = 4'h0,
    RG_PSEL = 4'h1,
    RG_FSEL = 4'h2,
    RG_DRV  = 4'h3,
    RG_PEN  = 4'h4,
    RG_PDIR = 4'h5
  } region_e;

  function automatic logic [3:0] drv_slot_mask(input logic wide);
    return wide ? 4'h7 : 4'h3;
  endfunction
endpackage

// File: rtl/pfr_unlock.sv
module pfr_unlock #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic         guard_hit,
  input  logic [W-1:0] wdata,
  output logic         prot_ok
);
  logic         armed_q;
  logic [W-1:0] key_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      key_q   <= '0;
    end else if (wr) begin
      if (guard_hit) begin
        armed_q <= !armed_q;
        key_q   <= wdata;
      end else begin
        armed_q <= 1'b0;
      end
    end
  end

  assign prot_ok = armed_q && (key_q == ~wdata);

  // R4: any non-guard write spends the unlock
  a_r4_unlock_spent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !guard_hit) |=> !prot_ok);

  // R5: guard write while armed disarms
  a_r5_double_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && guard_hit && armed_q) |=> !prot_ok);
endmodule

// File: rtl/pfr_store.sv
module pfr_store
  import pfr_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter logic [NUM_BANKS*32-1:0] DRV3_SEL = {(NUM_BANKS*2){16'h0F0F}}
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  psel_we,
  input  logic                                  fsel_we,
  input  logic                                  drv_we,
  input  logic                                  pen_we,
  input  logic                                  pdir_we,
  input  logic [IDX_W-1:0]                      idx,
  input  logic [REG_W-1:0]                      wdata,
  output logic [NUM_BANKS-1:0][REG_W-1:0]       psel_q,
  output logic [NUM_BANKS*4-1:0][REG_W-1:0]     fsel_q,
  output logic [NUM_BANKS*4-1:0][REG_W-1:0]     drv_q,
  output logic [NUM_BANKS-1:0][REG_W-1:0]       pen_q,
  output logic [NUM_BANKS-1:0][REG_W-1:0]       pdir_q
);
  localparam int NREG8 = NUM_BANKS * 4;

  logic [NREG8-1:0][REG_W-1:0] drv_mask;

  for (genvar r = 0; r < NREG8; r++) begin : g_mask
    for (genvar s = 0; s < 8; s++) begin : g_slot
      assign drv_mask[r][4*s +: 4] = drv_slot_mask(DRV3_SEL[r*8+s]);
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        psel_q[b] <= '0;
        pen_q[b]  <= '0;
        pdir_q[b] <= '0;
      end else begin
        if (psel_we && idx == IDX_W'(b)) psel_q[b] <= wdata;
        if (pen_we  && idx == IDX_W'(b)) pen_q[b]  <= wdata;
        if (pdir_we && idx == IDX_W'(b)) pdir_q[b] <= wdata;
      end
    end
  end

  for (genvar r = 0; r < NREG8; r++) begin : g_reg8
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fsel_q[r] <= '0;
        drv_q[r]  <= drv_mask[r];
      end else begin
        if (fsel_we && idx == IDX_W'(r)) fsel_q[r] <= wdata;
        if (drv_we  && idx == IDX_W'(r)) drv_q[r]  <= wdata & drv_mask[r];
      end
    end
  end

  // R3: pin select holds unless an accepted write targets it
  a_r3_psel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !psel_we |=> $stable(psel_q));

  // R8: bits outside each drive field stay zero
  a_r8_drive_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_q & ~drv_mask) == '0);
endmodule

// File: rtl/pinfunc_regfile.sv
module pinfunc_regfile
  import pfr_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter logic [NUM_BANKS*32-1:0] DRV3_SEL = {(NUM_BANKS*2){16'h0F0F}}
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [11:0]               bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      wp_violation,
  output logic [NUM_BANKS*32-1:0]   pad_periph_sel,
  output logic [NUM_BANKS*128-1:0]  pad_func,
  output logic [NUM_BANKS*96-1:0]   pad_drive,
  output logic [NUM_BANKS*32-1:0]   pad_pull_up,
  output logic [NUM_BANKS*32-1:0]   pad_pull_dn
);
  localparam int NUM_PINS = NUM_BANKS * 32;
  localparam int NREG8    = NUM_BANKS * 4;

  logic [3:0]       region;
  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             guard_hit, stat_hit;
  logic             psel_map, fsel_map, drv_map, pen_map, pdir_map, prot_map;
  logic             prot_ok;
  logic             viol_q;

  logic [NUM_BANKS-1:0][REG_W-1:0] psel_q, pen_q, pdir_q;
  logic [NREG8-1:0][REG_W-1:0]     fsel_q, drv_q;

  assign region  = bus_addr[11:8];
  assign idx     = bus_addr[7:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  assign guard_hit = aligned && region == RG_CTRL && idx == 6'd0;
  assign stat_hit  = aligned && region == RG_CTRL && idx == 6'd1;
  assign psel_map  = aligned && region == RG_PSEL && int'(idx) < NUM_BANKS;
  assign fsel_map  = aligned && region == RG_FSEL && int'(idx) < NREG8;
  assign drv_map   = aligned && region == RG_DRV  && int'(idx) < NREG8;
  assign pen_map   = aligned && region == RG_PEN  && int'(idx) < NUM_BANKS;
  assign pdir_map  = aligned && region == RG_PDIR && int'(idx) < NUM_BANKS;
  assign prot_map  = psel_map || fsel_map || drv_map;

  pfr_unlock #(.W(REG_W)) u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .guard_hit (guard_hit),
    .wdata     (bus_wdata),
    .prot_ok   (prot_ok)
  );

  pfr_store #(.NUM_BANKS(NUM_BANKS), .DRV3_SEL(DRV3_SEL)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel_we (bus_wr && psel_map && prot_ok),
    .fsel_we (bus_wr && fsel_map && prot_ok),
    .drv_we  (bus_wr && drv_map && prot_ok),
    .pen_we  (bus_wr && pen_map),
    .pdir_we (bus_wr && pdir_map),
    .idx     (idx),
    .wdata   (bus_wdata),
    .psel_q  (psel_q),
    .fsel_q  (fsel_q),
    .drv_q   (drv_q),
    .pen_q   (pen_q),
    .pdir_q  (pdir_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                                  viol_q <= 1'b0;
    else if (bus_wr && prot_map && !prot_ok)     viol_q <= 1'b1;
    else if (bus_wr && stat_hit && bus_wdata[0]) viol_q <= 1'b0;
  end
  assign wp_violation = viol_q;

  always_comb begin
    bus_rdata = '0;
    if (stat_hit) bus_rdata = {31'b0, viol_q};
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (idx == IDX_W'(i)) begin
        if (psel_map) bus_rdata = psel_q[i];
        if (pen_map)  bus_rdata = pen_q[i];
        if (pdir_map) bus_rdata = pdir_q[i];
      end
    end
    for (int i = 0; i < NREG8; i++) begin
      if (idx == IDX_W'(i)) begin
        if (fsel_map) bus_rdata = fsel_q[i];
        if (drv_map)  bus_rdata = drv_q[i];
      end
    end
  end

  assign pad_periph_sel = psel_q;
  assign pad_func       = fsel_q;
  assign pad_pull_up    = pen_q & pdir_q;
  assign pad_pull_dn    = pen_q & ~pdir_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pad_drive[3*p +: 3] = drv_q[p/8][4*(p%8) +: 3];
  end

  // R9: a pin never pulls both ways
  a_r9_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pull_up & pad_pull_dn) == '0);

  // R10: guard word reads as zero
  a_r10_guard_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    guard_hit |-> bus_rdata == '0);

  // R11: flag stays set until cleared by software
  a_r11_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_violation && !(bus_wr && stat_hit && bus_wdata[0])) |=> wp_violation);
endmodule

// File: tb/pinfunc_regfile_tb_top.sv
module pinfunc_regfile_tb_top;
  localparam int NB = 2;
  localparam int NP = NB * 32;
  localparam int N8 = NB * 4;
  localparam logic [NB*32-1:0] DSEL = {(NB*2){16'h0F0F}};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [11:0]       bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              wp_violation;
  logic [NP-1:0]     pad_periph_sel, pad_pull_up, pad_pull_dn;
  logic [NP*4-1:0]   pad_func;
  logic [NP*3-1:0]   pad_drive;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pinfunc_regfile #(.NUM_BANKS(NB), .DRV3_SEL(DSEL)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wp_violation(wp_violation),
    .pad_periph_sel(pad_periph_sel), .pad_func(pad_func), .pad_drive(pad_drive),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn)
  );

  // bench model
  logic [31:0] m_psel [NB];
  logic [31:0] m_pen  [NB];
  logic [31:0] m_pdir [NB];
  logic [31:0] m_fsel [N8];
  logic [31:0] m_drv  [N8];
  logic        m_armed, m_viol;
  logic [31:0] m_key;

  function automatic logic [31:0] dmask(input int r);
    logic [31:0] m = '0;
    for (int s = 0; s < 8; s++) m[4*s +: 4] = DSEL[r*8+s] ? 4'h7 : 4'h3;
    return m;
  endfunction

  function automatic void m_reset();
    for (int b = 0; b < NB; b++) begin m_psel[b] = '0; m_pen[b] = '0; m_pdir[b] = '0; end
    for (int r = 0; r < N8; r++) begin m_fsel[r] = '0; m_drv[r] = dmask(r); end
    m_armed = 0; m_viol = 0; m_key = '0;
  endfunction

  function automatic void m_write(input logic [11:0] a, input logic [31:0] d);
    int rg = int'(a[11:8]);
    int ix = int'(a[7:2]);
    bit al = (a[1:0] == 2'b00);
    bit ok;
    if (al && rg == 0 && ix == 0) begin
      m_armed = !m_armed; m_key = d; return;
    end
    ok = m_armed && (m_key == ~d);
    m_armed = 0;
    if (!al) return;
    if ((rg == 1 && ix < NB) || (rg == 2 && ix < N8) || (rg == 3 && ix < N8)) begin
      if (!ok) m_viol = 1;
      else if (rg == 1) m_psel[ix] = d;
      else if (rg == 2) m_fsel[ix] = d;
      else m_drv[ix] = d & dmask(ix);
    end else if (rg == 0 && ix == 1 && d[0]) m_viol = 0;
    else if (rg == 4 && ix < NB) m_pen[ix] = d;
    else if (rg == 5 && ix < NB) m_pdir[ix] = d;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int rg = int'(a[11:8]);
    int ix = int'(a[7:2]);
    if (a[1:0] != 2'b00) return '0;
    if (rg == 0 && ix == 1) return {31'b0, m_viol};
    if (rg == 1 && ix < NB) return m_psel[ix];
    if (rg == 2 && ix < N8) return m_fsel[ix];
    if (rg == 3 && ix < N8) return m_drv[ix];
    if (rg == 4 && ix < NB) return m_pen[ix];
    if (rg == 5 && ix < NB) return m_pdir[ix];
    return '0;
  endfunction

  task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    m_write(a, d);
  endtask

  task automatic rd_check(input string tag, input logic [11:0] a);
    bus_addr = a;
    #1;
    check(tag, 512'(bus_rdata), 512'(m_read(a)));
  endtask

  task automatic unlock_wr(input logic [11:0] a, input logic [31:0] d);
    wr(12'h000, ~d);
    wr(a, d);
  endtask

  task automatic pads_check(input string tag);
    logic [NP-1:0]   e_ps, e_up, e_dn;
    logic [NP*4-1:0] e_fn;
    logic [NP*3-1:0] e_dr;
    for (int p = 0; p < NP; p++) begin
      e_ps[p] = m_psel[p/32][p%32];
      e_up[p] = m_pen[p/32][p%32] & m_pdir[p/32][p%32];
      e_dn[p] = m_pen[p/32][p%32] & ~m_pdir[p/32][p%32];
      e_fn[4*p +: 4] = m_fsel[p/8][4*(p%8) +: 4];
      e_dr[3*p +: 3] = m_drv[p/8][4*(p%8) +: 3];
    end
    check({tag, " R6 psel"}, 512'(pad_periph_sel), 512'(e_ps));
    check({tag, " R7 func"}, 512'(pad_func), 512'(e_fn));
    check({tag, " R8 drive"}, 512'(pad_drive), 512'(e_dr));
    check({tag, " R9 up"}, 512'(pad_pull_up), 512'(e_up));
    check({tag, " R9 dn"}, 512'(pad_pull_dn), 512'(e_dn));
    check({tag, " R11 flag"}, 512'(wp_violation), 512'(m_viol));
  endtask

  task automatic all_regs_check(input string tag);
    rd_check({tag, " R11 status"}, 12'h004);
    for (int b = 0; b < NB; b++) begin
      rd_check({tag, " psel"}, 12'h100 + 12'(4*b));
      rd_check({tag, " R9 pen"}, 12'h400 + 12'(4*b));
      rd_check({tag, " R9 pdir"}, 12'h500 + 12'(4*b));
    end
    for (int r = 0; r < N8; r++) begin
      rd_check({tag, " fsel"}, 12'h200 + 12'(4*r));
      rd_check({tag, " drv"}, 12'h300 + 12'(4*r));
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    all_regs_check("R1 reset");
    pads_check("R1 reset");

    // R2 accepted unlock, R6 mapping
    unlock_wr(12'h100, 32'h0000_80F1);
    rd_check("R2 psel0", 12'h100);
    pads_check("R2 R6");
    unlock_wr(12'h104, 32'h8000_0001);
    pads_check("R6 bank1");

    // R3 wrong key
    wr(12'h000, ~32'h1234_5678 ^ 32'h1);
    wr(12'h104, 32'h1234_5678);
    rd_check("R3 badkey", 12'h104);
    rd_check("R3 R11 flag", 12'h004);
    pads_check("R3 badkey");
    wr(12'h004, 32'h1);
    rd_check("R11 cleared", 12'h004);

    // R3 no unlock at all
    wr(12'h200, 32'hDEAD_BEEF);
    rd_check("R3 nounlock", 12'h200);
    check("R3 R11 flag set", 512'(wp_violation), 512'(1'b1));
    wr(12'h004, 32'h0);
    check("R11 no clear on bit0=0", 512'(wp_violation), 512'(1'b1));
    wr(12'h004, 32'h1);

    // R4 spent by use, and by intervening write
    unlock_wr(12'h200, 32'h7654_3210);
    wr(12'h200, 32'hFFFF_FFFF);
    rd_check("R4 second dropped", 12'h200);
    pads_check("R7 R4");
    wr(12'h000, ~32'hABCD_0123);
    wr(12'h400, 32'h0000_00FF);
    wr(12'h204, 32'hABCD_0123);
    rd_check("R4 intervening", 12'h204);
    wr(12'h004, 32'h1);

    // R5 double guard
    wr(12'h000, ~32'h1111_2222);
    wr(12'h000, ~32'h1111_2222);
    wr(12'h204, 32'h1111_2222);
    rd_check("R5 double guard", 12'h204);
    check("R5 flag", 512'(wp_violation), 512'(1'b1));
    wr(12'h004, 32'h1);

    // R8 drive widths
    unlock_wr(12'h300, 32'hFFFF_FFFF);
    rd_check("R8 mask", 12'h300);
    unlock_wr(12'h304, 32'h0000_0000);
    rd_check("R8 zero", 12'h304);
    unlock_wr(12'h308, 32'h5A5A_5A5A);
    pads_check("R8");

    // R9 pull combinations
    wr(12'h400, 32'h0000_000C);
    wr(12'h500, 32'h0000_000A);
    pads_check("R9");
    rd_check("R9 pdir", 12'h500);

    // R10 guard/unmapped reads and writes
    rd_check("R10 guard", 12'h000);
    rd_check("R10 unmapped", 12'h7F0);
    rd_check("R10 misaligned", 12'h101);
    rd_check("R10 oob", 12'h108);
    wr(12'h600, 32'hFFFF_FFFF);
    wr(12'h000, ~32'hFFFF_FFFF);
    wr(12'h108, 32'hFFFF_FFFF);
    wr(12'h401, 32'hFFFF_FFFF);
    all_regs_check("R10 no effect");
    pads_check("R10");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int kind = int'($urandom_range(0, 3));
      logic [31:0] d = $urandom;
      logic [11:0] a;
      if (kind == 0) begin
        a = {4'(1 + $urandom_range(0, 2)), 6'($urandom_range(0, NB - 1)), 2'b00};
        unlock_wr(a, d);
      end else if (kind == 1) begin
        a = {4'($urandom_range(0, 6)), 6'($urandom_range(0, 9)), 2'($urandom_range(0, 3) == 0 ? 1 : 0)};
        wr(a, d);
      end else if (kind == 2) begin
        wr(12'h000, ($urandom_range(0, 1) == 1) ? ~d : d);
      end else begin
        a = {4'($urandom_range(1, 5)), 6'($urandom_range(0, 3)), 2'b00};
        wr(a, d);
      end
      pads_check("rand");
      if (it % 50 == 49) all_regs_check("rand regs");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule